// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a reconfigurable two-level logic plane. It takes 29 single-bit array inputs and offers each of them to every AND gate in both true and inverted form, so each gate sees 58 literal columns. A connection memory chooses which literals each gate uses. The gates that carry logic feed a fixed OR stage. Outputs do not all get the same number of gates: eight outputs get 4 gates each, four get 8, and four get 12. Further gates are not ORed at all and come out one by one as control terms. These are two global terms and four per-output families, which surrounding cells can use as output enable, asynchronous set, asynchronous clear and clock or latch enable.

The connection memory is loaded through a plain row write port. Each write supplies one row index and all 58 connection bits of that gate. A written row keeps its contents until it is written again. The path from the array inputs to every output is purely combinational. The clock only moves new connection rows into the memory.

Top module: `sop_array`

## Requirements
- R1: While `rstN` is low, and after it rises with no write made, every row holds no connection. Every gate is then TRUE, so every output bit is 1.
- R2: A gate whose row has no connection bit set is TRUE for any value of `arrayIn`.
- R3: A gate whose row sets both bit 2i and bit 2i+1 for some input i is FALSE for any value of `arrayIn`.
- R4: In a row, bit 2i connects `arrayIn[i]` and bit 2i+1 connects its inverse. A gate is the AND of the literals its row connects.
- R5: `sumOut[k]` is the OR of a fixed range of rows. For k in 0..7 the range is rows 4k..4k+3. For k in 8..11 it is rows 32+8(k-8) to 39+8(k-8). For k in 12..15 it is rows 64+12(k-12) to 75+12(k-12).
- R6: The control rows come out unsummed. Row 112 drives `preloadTerm` and row 113 drives `observeTerm`. For output k, row 114+k drives `oeTerm[k]`, row 130+k drives `presetTerm[k]`, row 146+k drives `resetTerm[k]`, and row 162+k drives `clkTerm[k]`.
- R7: A write with `wrEn` high replaces row `wrAddr` with `wrRow` at the next rising clock edge and not before. With `wrEn` low, no row changes, whatever `wrAddr` and `wrRow` hold.
- R8: A write to a `wrAddr` of 178 or more changes no row.
- R9: A change on `arrayIn` reaches the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for row writes |
| rstN | input | 1 | Asynchronous active-low reset; clears all rows |
| arrayIn | input | 29 | Array input signals |
| wrEn | input | 1 | Row write strobe |
| wrAddr | input | 8 | Row index to write |
| wrRow | input | 58 | Connection bits for the row |
| sumOut | output | 16 | Summed logic outputs |
| preloadTerm | output | 1 | Global control term (row 112) |
| observeTerm | output | 1 | Global control term (row 113) |
| oeTerm | output | 16 | Per-output enable terms |
| presetTerm | output | 16 | Per-output set terms |
| resetTerm | output | 16 | Per-output clear terms |
| clkTerm | output | 16 | Per-output clock or latch-enable terms |

## Verification
The assertions assume that `wrEn`, `wrAddr` and `wrRow` hold known values at every rising edge, and that `arrayIn` never carries X. The row-hold and row-write properties compare memory rows from one edge to the next and would be meaningless on unknown strobes. The stimulus drives every input on the falling edge, keeps `wrEn` low except for single-cycle writes, and does all of its out-of-range writes at indices 178 and above with otherwise legal data. The checks are made half a cycle away from the write edges.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;
  localparam int NUM_IN    = 29;
  localparam int COLS      = 2 * NUM_IN;
  localparam int NUM_OUT   = 16;
  localparam int SMALL_N   = 8;
  localparam int MID_N     = 4;
  localparam int SMALL_PT  = 4;
  localparam int MID_PT    = 8;
  localparam int LARGE_PT  = 12;

  // number of summed gates feeding output k
  function automatic int ptCount(input int k);
    if (k < SMALL_N) return SMALL_PT;
    else if (k < SMALL_N + MID_N) return MID_PT;
    else return LARGE_PT;
  endfunction

  // first row of output k; ptBase(NUM_OUT) is the logic row total
  function automatic int ptBase(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += ptCount(j);
    return acc;
  endfunction

  localparam int LOGIC_ROWS  = ptBase(NUM_OUT);
  localparam int PRELOAD_ROW = LOGIC_ROWS;
  localparam int OBSERVE_ROW = LOGIC_ROWS + 1;
  localparam int OE_BASE     = LOGIC_ROWS + 2;
  localparam int PRESET_BASE = OE_BASE + NUM_OUT;
  localparam int RESET_BASE  = PRESET_BASE + NUM_OUT;
  localparam int CLKE_BASE   = RESET_BASE + NUM_OUT;
  localparam int TOTAL_ROWS  = CLKE_BASE + NUM_OUT;
  localparam int ROW_W       = $clog2(TOTAL_ROWS);

  typedef logic [COLS-1:0] connRow_t;

  typedef struct packed {
    logic             wr;
    logic [ROW_W-1:0] row;
    connRow_t         data;
  } rowStrobe_t;

  function automatic logic hasConflict(input connRow_t r);
    logic c;
    c = 1'b0;
    for (int i = 0; i < NUM_IN; i++) c |= r[2*i] & r[2*i+1];
    return c;
  endfunction
endpackage

// File: rtl/sop_array_ctrl.sv
module sop_array_ctrl
  import sop_array_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [ROW_W-1:0] wrAddr,
  input  connRow_t         wrRow,
  output rowStrobe_t       strobe
);
  logic inRange;

  assign inRange     = (int'(wrAddr) < TOTAL_ROWS);
  assign strobe.wr   = wrEn & inRange;
  assign strobe.row  = wrAddr;
  assign strobe.data = wrRow;

  // R8: indices past the last row never turn into a write strobe
  p_drop_far_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) >= TOTAL_ROWS) |-> !strobe.wr);

  // R7: no strobe without the write enable
  p_no_write_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !strobe.wr);
endmodule

// File: rtl/sop_array_dp.sv
module sop_array_dp
  import sop_array_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  rowStrobe_t            strobe,
  input  logic [NUM_IN-1:0]     arrayIn,
  output logic [TOTAL_ROWS-1:0] ptVal,
  output logic [NUM_OUT-1:0]    sumOut
);
  connRow_t connMem [TOTAL_ROWS];
  connRow_t litVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < TOTAL_ROWS; r++) connMem[r] <= '0;
    end else if (strobe.wr) begin
      connMem[strobe.row] <= strobe.data;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      litVec[2*i]   = arrayIn[i];
      litVec[2*i+1] = ~arrayIn[i];
    end
  end

  for (genvar r = 0; r < TOTAL_ROWS; r++) begin : g_row
    assign ptVal[r] = &(~connMem[r] | litVec);

    p_empty_row_true_r2: assert property (@(posedge clk) disable iff (!rstN)
      (connMem[r] == '0) |-> ptVal[r]);
    p_conflict_false_r3: assert property (@(posedge clk) disable iff (!rstN)
      hasConflict(connMem[r]) |-> !ptVal[r]);
    p_row_write_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wr && int'(strobe.row) == r) |=> (connMem[r] == $past(strobe.data)));
    p_row_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.wr && int'(strobe.row) == r) |=> $stable(connMem[r]));
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_sum
    localparam int BASE = ptBase(k);
    localparam int CNT  = ptCount(k);
    assign sumOut[k] = |ptVal[BASE +: CNT];

    p_first_row_feeds_r5: assert property (@(posedge clk) disable iff (!rstN)
      (connMem[BASE] == '0) |-> sumOut[k]);
    p_last_row_feeds_r5: assert property (@(posedge clk) disable iff (!rstN)
      (connMem[BASE+CNT-1] == '0) |-> sumOut[k]);
  end
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IN-1:0]   arrayIn,
  input  logic                wrEn,
  input  logic [ROW_W-1:0]    wrAddr,
  input  logic [COLS-1:0]     wrRow,
  output logic [NUM_OUT-1:0]  sumOut,
  output logic                preloadTerm,
  output logic                observeTerm,
  output logic [NUM_OUT-1:0]  oeTerm,
  output logic [NUM_OUT-1:0]  presetTerm,
  output logic [NUM_OUT-1:0]  resetTerm,
  output logic [NUM_OUT-1:0]  clkTerm
);
  rowStrobe_t            strobe;
  logic [TOTAL_ROWS-1:0] ptVal;

  sop_array_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrRow  (wrRow),
    .strobe (strobe)
  );

  sop_array_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .arrayIn (arrayIn),
    .ptVal   (ptVal),
    .sumOut  (sumOut)
  );

  assign preloadTerm = ptVal[PRELOAD_ROW];
  assign observeTerm = ptVal[OBSERVE_ROW];
  assign oeTerm      = ptVal[OE_BASE     +: NUM_OUT];
  assign presetTerm  = ptVal[PRESET_BASE +: NUM_OUT];
  assign resetTerm   = ptVal[RESET_BASE  +: NUM_OUT];
  assign clkTerm     = ptVal[CLKE_BASE   +: NUM_OUT];
endmodule

// File: tb/sop_array_test.sv
`timescale 1ns/1ps
module sop_array_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [28:0] arrayIn = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [57:0] wrRow = '0;
  logic [15:0] sumOut, oeTerm, presetTerm, resetTerm, clkTerm;
  logic        preloadTerm, observeTerm;
  logic [81:0] obs;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  localparam logic [57:0] FALSE_ROW = 58'h3;   // input 0 in both polarities (R3)
  localparam logic [57:0] EMPTY_ROW = 58'h0;
  // R4 row: in0 true (bit 0), in1 inverted (bit 3), in28 true (bit 56)
  localparam logic [57:0] LIT_ROW = 58'h1 | 58'h8 | (58'h1 << 56);
  // {arrayIn, expected sumOut[0]}
  localparam logic [29:0] VEC [6] = '{
    {29'h0000_0000, 1'b0},
    {29'h1000_0001, 1'b1},
    {29'h1000_0003, 1'b0},
    {29'h0000_0001, 1'b0},
    {29'h1FFF_FFFD, 1'b1},
    {29'h1000_0021, 1'b1}
  };

  always #2 clk = ~clk;

  sop_array uut (
    .clk(clk), .rstN(rstN), .arrayIn(arrayIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrRow(wrRow), .sumOut(sumOut), .preloadTerm(preloadTerm),
    .observeTerm(observeTerm), .oeTerm(oeTerm), .presetTerm(presetTerm),
    .resetTerm(resetTerm), .clkTerm(clkTerm)
  );

  assign obs = {clkTerm, resetTerm, presetTerm, oeTerm, observeTerm, preloadTerm, sumOut};

  function automatic int firstRow(int k);
    if (k < 8) return 4 * k;
    else if (k < 12) return 32 + 8 * (k - 8);
    else return 64 + 12 * (k - 12);
  endfunction

  function automatic int rowCount(int k);
    if (k < 8) return 4;
    else if (k < 12) return 8;
    else return 12;
  endfunction

  task automatic chk(input string tag, input logic [81:0] act, input logic [81:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeRow(input int addr, input logic [57:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'(addr); wrRow = data;
    @(negedge clk);
    wrEn = 1'b0;
    #0.5;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    chk("R1 reset state during reset", obs, {82{1'b1}});
    rstN = 1'b1;
    @(negedge clk); #0.5;
    chk("R1 reset state after release", obs, {82{1'b1}});
    arrayIn = 29'h0ABC_1234; #0.5;
    chk("R2 empty rows true on other inputs", obs, {82{1'b1}});

    for (int r = 0; r < 178; r++) writeRow(r, FALSE_ROW);
    chk("R3 conflict rows all false", obs, '0);
    arrayIn = '1; #0.5;
    chk("R3 conflict rows false on all-ones", obs, '0);

    // R4 / R9 table: combinational, checked inside one half cycle
    writeRow(1, LIT_ROW);
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      arrayIn = VEC[v][29:1];
      #0.5;
      chk($sformatf("R4 R9 vector %0d", v), obs, {81'b0, VEC[v][0]});
    end
    writeRow(1, FALSE_ROW);

    // R5: first and last rows of every output
    arrayIn = 29'h1555_5555;
    for (int k = 0; k < 16; k++) begin
      writeRow(firstRow(k), EMPTY_ROW);
      chk($sformatf("R5 R2 first row out %0d", k), obs, 82'(1) << k);
      writeRow(firstRow(k), FALSE_ROW);
      writeRow(firstRow(k) + rowCount(k) - 1, EMPTY_ROW);
      chk($sformatf("R5 last row out %0d", k), obs, 82'(1) << k);
      writeRow(firstRow(k) + rowCount(k) - 1, FALSE_ROW);
    end

    // R6: control rows 112..177 map to obs bits 16..81
    for (int c = 0; c < 66; c++) begin
      writeRow(112 + c, EMPTY_ROW);
      chk($sformatf("R6 control row %0d", 112 + c), obs, 82'(1) << (16 + c));
      writeRow(112 + c, FALSE_ROW);
    end

    // R8: out-of-range writes
    writeRow(178, EMPTY_ROW);
    writeRow(200, EMPTY_ROW);
    writeRow(255, EMPTY_ROW);
    chk("R8 out-of-range writes ignored", obs, '0);

    // R7: write timing and hold
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'd0; wrRow = EMPTY_ROW;
    #0.5;
    chk("R7 no change before edge", obs, '0);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 8'd4; wrRow = EMPTY_ROW;
    #0.5;
    chk("R7 row written after edge", obs, 82'(1));
    repeat (3) @(negedge clk);
    #0.5;
    chk("R7 rows held with write enable low", obs, 82'(1));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule